// File: doc/BRIEF.md
# DMA Stream Transfer Counter

This block keeps the per-stream state of one DMA channel. It holds a 16-bit item counter, the value last programmed into it, a peripheral address and two memory base addresses used for ping-pong buffering. It does not move data or arbitrate. A bus master elsewhere reads the addresses, watches `serve_ok`, and pulses `xfer_done` once for each item it has moved. The block counts those items down. It raises a half-way pulse and a completion pulse, and it either stops at zero, reloads, or swaps buffers.

Software programs the block through a single write port (`wr_en`, `wr_sel`, `wr_data`). Select codes: 0 = control, 1 = item count, 2 = peripheral address, 3 = memory base 0, 4 = memory base 1. Control word bits: bit 0 enable, bit 1 circular reload, bit 2 double-buffer (implies reload), bit 3 initial current-target. A three-state machine sequences the stream:
- IDLE: the stream is disabled.
- RUN: the stream is enabled with a nonzero count, and requests are served.
- DRAINED: the stream is enabled but the count is zero.

Its transitions are:
- Start: IDLE to RUN, on an enabling control write when the programmed count is nonzero.
- Start-empty: IDLE to DRAINED, on an enabling control write when the programmed count is zero.
- Finish: RUN to DRAINED, on the last item when neither reload mode is set.
- Wrap: RUN to RUN, on the last item with reload.
- Stop: RUN or DRAINED to IDLE, on a control write with bit 0 clear.

Top module: `dma_stream_ctx`

## Requirements
- R1: After reset, `remaining`, all three addresses, `stream_on`, `cur_target`, `serve_ok`, `half_pulse` and `done_pulse` are all zero.
- R2: A count write (select 1) while disabled sets both the programmed count and `remaining` to `wr_data[15:0]`. Bits 31:16 of `remaining` always read zero.
- R3: A count write while the stream is enabled is ignored. Neither `remaining` nor the programmed value changes.
- R4: Each `xfer_done` accepted in RUN lowers `remaining` by one. An `xfer_done` is ignored when `serve_ok` is low.
- R5: The item that takes `remaining` from 1 to 0 gives a one-cycle `done_pulse` in the following cycle. Without reload modes, `remaining` then stays 0 and `serve_ok` falls (Finish).
- R6: With circular (bit 1) or double-buffer (bit 2) set, the last item reloads the programmed count and `serve_ok` stays high (Wrap).
- R7: An enabling control write while disabled reloads `remaining` from the programmed count. If that count is 0, `serve_ok` stays low (Start-empty).
- R8: For a programmed count P of 2 or more, `half_pulse` fires for one cycle after the item that leaves `remaining` equal to floor(P/2).
- R9: The peripheral address (select 2) accepts writes only while disabled.
- R10: Memory base 0 (select 3) accepts writes when disabled, or when enabled in double-buffer mode with `cur_target` = 1. Memory base 1 (select 4) accepts writes when disabled, or when enabled in double-buffer mode with `cur_target` = 0. Any other write to either is ignored.
- R11: In double-buffer mode each completion toggles `cur_target`. `active_mem_addr` shows base 1 when `cur_target` is 1 and base 0 otherwise.
- R12: Control bits 1 to 3 are taken only while disabled. A disabling control write in the same cycle as `xfer_done` wins, and the item is not counted.
- R13: `serve_ok` is high exactly when the stream is enabled and `remaining` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 ctrl, 1 count, 2 periph, 3 mem0, 4 mem1) |
| wr_data | input | 32 | Write data |
| xfer_done | input | 1 | One item moved by the bus master |
| remaining | output | 32 | Items left, upper 16 bits zero |
| stream_on | output | 1 | Stream enabled |
| cur_target | output | 1 | Current memory target |
| serve_ok | output | 1 | Requests may be served |
| half_pulse | output | 1 | Half-way pulse |
| done_pulse | output | 1 | Completion pulse |
| periph_addr | output | 32 | Peripheral address |
| mem0_addr | output | 32 | Memory base 0 |
| mem1_addr | output | 32 | Memory base 1 |
| active_mem_addr | output | 32 | Base selected by `cur_target` |

## Verification
Suppose the state register and the counter disagree, for example RUN holding a zero count. Then `serve_ok` is wrong in the same cycle as `remaining`, and the bench sees the mismatch at its next sample. A counter that is off by one shows up after the first accepted item. It is caught at the latest one item later, because `done_pulse` or `half_pulse` then lands in the wrong cycle. A broken reload or target toggle shows on `remaining` and `active_mem_addr` in the cycle right after the last item of a pass.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_PADDR = 3'd2,
        SEL_MEM0  = 3'd3,
        SEL_MEM1  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_DRAINED = 2'd2
    } stream_state_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_CIRC = 1;
    localparam int CTRL_DBUF = 2;
    localparam int CTRL_TGT  = 3;
    localparam int CTRL_W    = 4;
endpackage

// File: rtl/stream_fsm.sv
module stream_fsm
    import dma_stream_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_bits,
    input  logic                xfer_done,
    input  logic                last_item,
    input  logic                prog_zero,
    output stream_state_e       state,
    output logic                start,
    output logic                xfer_take,
    output logic                reload,
    output logic                dbuf,
    output logic                target
);
    stream_state_e state_nx;
    logic          circ;
    logic          stop_req;
    logic          finish;

    always_comb begin
        stop_req  = ctrl_wr && !ctrl_bits[CTRL_EN];
        start     = (state == ST_IDLE) && ctrl_wr && ctrl_bits[CTRL_EN];
        xfer_take = (state == ST_RUN) && xfer_done && !stop_req;
        reload    = circ || dbuf;
        finish    = xfer_take && last_item;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = prog_zero ? ST_DRAINED : ST_RUN;
            end
            ST_RUN: begin
                if (stop_req)              state_nx = ST_IDLE;
                else if (finish && !reload) state_nx = ST_DRAINED;
            end
            ST_DRAINED: begin
                if (stop_req) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            circ   <= 1'b0;
            dbuf   <= 1'b0;
            target <= 1'b0;
        end else if (state == ST_IDLE && ctrl_wr) begin
            circ   <= ctrl_bits[CTRL_CIRC];
            dbuf   <= ctrl_bits[CTRL_DBUF];
            target <= ctrl_bits[CTRL_TGT];
        end else if (finish && dbuf) begin
            target <= ~target;
        end
    end

    p_modes_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !finish) |=> $stable(target));
    p_finish_leaves_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !reload) |=> (state == ST_DRAINED));
endmodule

// File: rtl/stream_counter.sv
module stream_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_data,
    input  logic             start,
    input  logic             xfer_take,
    input  logic             reload,
    input  logic             enabled,
    output logic [CNT_W-1:0] remaining,
    output logic             last_item,
    output logic             prog_zero,
    output logic             half_pulse,
    output logic             done_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] prog;
    logic [CNT_W-1:0] half_mark;
    logic [CNT_W-1:0] next_rem;

    always_comb begin
        last_item = (remaining == ONE);
        prog_zero = (prog == '0);
        half_mark = prog >> 1;
        next_rem  = remaining - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog      <= '0;
            remaining <= '0;
        end else if (count_wr) begin
            prog      <= count_data;
            remaining <= count_data;
        end else if (start) begin
            remaining <= prog;
        end else if (xfer_take) begin
            remaining <= (last_item && reload) ? prog : next_rem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_pulse <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            half_pulse <= xfer_take && (prog > ONE) && (next_rem == half_mark);
            done_pulse <= xfer_take && last_item;
        end
    end

    p_prog_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(prog));
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_take && remaining > ONE) |=> (remaining == $past(remaining) - ONE));
    p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (remaining == '0 || reload));
    p_half_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (half_pulse && !reload) |-> (remaining == half_mark));
endmodule

// File: rtl/stream_addr_regs.sv
module stream_addr_regs
    import dma_stream_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              enabled,
    input  logic              dbuf,
    input  logic              target,
    output logic [ADDR_W-1:0] periph_addr,
    output logic [ADDR_W-1:0] mem_addr [2]
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          periph_addr <= '0;
        else if (wr_en && wr_sel == SEL_PADDR && !enabled)   periph_addr <= wr_data;
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam reg_sel_e BANK_SEL = (b == 0) ? SEL_MEM0 : SEL_MEM1;
        logic open_now;
        always_comb open_now = !enabled || (dbuf && (target != b[0]));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     mem_addr[b] <= '0;
            else if (wr_en && wr_sel == BANK_SEL && open_now) mem_addr[b] <= wr_data;
        end
        p_bank_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (enabled && !(dbuf && target != b[0])) |=> $stable(mem_addr[b]));
    end

    p_periph_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(periph_addr));
endmodule

// File: rtl/dma_stream_ctx.sv
module dma_stream_ctx
    import dma_stream_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer_done,
    output logic [DATA_W-1:0] remaining,
    output logic              stream_on,
    output logic              cur_target,
    output logic              serve_ok,
    output logic              half_pulse,
    output logic              done_pulse,
    output logic [DATA_W-1:0] periph_addr,
    output logic [DATA_W-1:0] mem0_addr,
    output logic [DATA_W-1:0] mem1_addr,
    output logic [DATA_W-1:0] active_mem_addr
);
    stream_state_e    state;
    logic             start, xfer_take, reload, dbuf;
    logic             last_item, prog_zero;
    logic             ctrl_wr, count_wr;
    logic [CNT_W-1:0] rem_cnt;
    logic [DATA_W-1:0] banks [2];

    always_comb begin
        stream_on       = (state != ST_IDLE);
        serve_ok        = (state == ST_RUN);
        ctrl_wr         = wr_en && (wr_sel == SEL_CTRL);
        count_wr        = wr_en && (wr_sel == SEL_COUNT) && !stream_on;
        remaining       = DATA_W'(rem_cnt);
        mem0_addr       = banks[0];
        mem1_addr       = banks[1];
        active_mem_addr = cur_target ? banks[1] : banks[0];
    end

    stream_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (wr_data[CTRL_W-1:0]),
        .xfer_done (xfer_done),
        .last_item (last_item),
        .prog_zero (prog_zero),
        .state     (state),
        .start     (start),
        .xfer_take (xfer_take),
        .reload    (reload),
        .dbuf      (dbuf),
        .target    (cur_target)
    );

    stream_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_wr   (count_wr),
        .count_data (wr_data[CNT_W-1:0]),
        .start      (start),
        .xfer_take  (xfer_take),
        .reload     (reload),
        .enabled    (stream_on),
        .remaining  (rem_cnt),
        .last_item  (last_item),
        .prog_zero  (prog_zero),
        .half_pulse (half_pulse),
        .done_pulse (done_pulse)
    );

    stream_addr_regs #(.ADDR_W(DATA_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .enabled     (stream_on),
        .dbuf        (dbuf),
        .target      (cur_target),
        .periph_addr (periph_addr),
        .mem_addr    (banks)
    );

    p_serve_nonzero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        serve_ok |-> (rem_cnt != '0));
    p_idle_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serve_ok && !count_wr && !start) |=> $stable(rem_cnt));
    p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({half_pulse, done_pulse}));
endmodule

// File: tb/tb_dma_stream_ctx.sv
`timescale 1ns/1ps
module tb_dma_stream_ctx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        xfer_done = 1'b0;
    logic [31:0] remaining, periph_addr, mem0_addr, mem1_addr, active_mem_addr;
    logic        stream_on, cur_target, serve_ok, half_pulse, done_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_stream_ctx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_done(xfer_done), .remaining(remaining), .stream_on(stream_on),
        .cur_target(cur_target), .serve_ok(serve_ok), .half_pulse(half_pulse),
        .done_pulse(done_pulse), .periph_addr(periph_addr), .mem0_addr(mem0_addr),
        .mem1_addr(mem1_addr), .active_mem_addr(active_mem_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 remaining", remaining, 0);
        chk("R1 addrs", periph_addr | mem0_addr | mem1_addr, 0);
        chk("R1 flags", {27'd0, stream_on, cur_target, serve_ok, half_pulse, done_pulse}, 0);
        rst_n = 1'b1;

        // R2 upper bits dropped
        wr(3'd1, 32'hABCD_0005);
        chk("R2 count load", remaining, 32'h5);

        // R4/R5/R8 sweep of normal-mode runs
        for (int n = 1; n <= 12; n++) begin
            wr(3'd1, n);
            wr(3'd0, 32'h1);
            chk("R7 start reload", remaining, n);
            chk("R13 serve on", serve_ok, 1);
            for (int k = 1; k <= n; k++) begin
                xfer();
                chk("R4 decrement", remaining, n - k);
                chk("R8 half pulse", half_pulse, (n >= 2 && (n - k) == n / 2));
                chk("R5 done pulse", done_pulse, (k == n));
            end
            chk("R5 serve off", serve_ok, 0);
            xfer();
            chk("R4 ignored when idle", remaining, 0);
            chk("R5 no repeat", done_pulse, 0);
            wr(3'd0, 32'h0);
        end

        // R7 re-enable reloads last programmed value (12)
        wr(3'd0, 32'h1);
        chk("R7 re-enable", remaining, 12);
        // R3 count write while enabled ignored
        wr(3'd1, 32'd3);
        chk("R3 count locked", remaining, 12);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h1);
        chk("R3 prog unchanged", remaining, 12);
        // R12 disable beats transfer
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0; xfer_done = 1'b1;
        @(negedge clk); wr_en = 1'b0; xfer_done = 1'b0;
        chk("R12 disable priority", remaining, 12);
        chk("R12 stream off", stream_on, 0);

        // R7 enable with zero
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h1);
        chk("R7 empty start", serve_ok, 0);
        chk("R7 empty enabled", stream_on, 1);
        wr(3'd0, 32'h0);

        // R12 modes locked while enabled
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h3);
        xfer(); xfer();
        chk("R12 circ ignored", remaining, 0);
        chk("R12 serve", serve_ok, 0);
        wr(3'd0, 32'h0);

        // R9 peripheral address
        wr(3'd2, 32'h4000_1000);
        chk("R9 write disabled", periph_addr, 32'h4000_1000);
        // R6 circular without double buffer
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h3);
        wr(3'd2, 32'h5555_5555);
        chk("R9 locked", periph_addr, 32'h4000_1000);
        for (int k = 1; k <= 7; k++) begin
            xfer();
            chk("R6 circular count", remaining, (k % 3 == 0) ? 3 : 3 - (k % 3));
            chk("R6 serving", serve_ok, 1);
            chk("R11 no toggle", cur_target, 0);
        end
        wr(3'd0, 32'h0);

        // R10/R11 double buffer
        wr(3'd3, 32'h2000_0000);
        wr(3'd4, 32'h3000_0000);
        chk("R10 mem0 disabled", mem0_addr, 32'h2000_0000);
        wr(3'd1, 32'd4);
        wr(3'd0, 32'h5);
        chk("R11 active base0", active_mem_addr, 32'h2000_0000);
        wr(3'd3, 32'h2222_2222);
        chk("R10 mem0 locked", mem0_addr, 32'h2000_0000);
        wr(3'd4, 32'h3333_3333);
        chk("R10 mem1 open", mem1_addr, 32'h3333_3333);
        for (int k = 1; k <= 12; k++) begin
            xfer();
            chk("R6 dbuf count", remaining, (k % 4 == 0) ? 4 : 4 - (k % 4));
            chk("R11 target", cur_target, (k / 4) % 2);
            chk("R11 active addr", active_mem_addr,
                ((k / 4) % 2 == 1) ? 32'h3333_3333 : 32'h2000_0000);
        end
        wr(3'd3, 32'h2444_4444);
        chk("R10 mem0 open", mem0_addr, 32'h2444_4444);
        wr(3'd4, 32'h3555_5555);
        chk("R10 mem1 locked", mem1_addr, 32'h3333_3333);
        wr(3'd0, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule